// File: doc/BRIEF.md
# Reloadable Two-Plane Sum-of-Products Logic Array

This block evaluates a two-level logic function whose structure is held in internal registers. A first plane turns the primary inputs into a set of intermediate terms. A second plane combines those terms into the outputs. Each row of either plane says which literals take part in its term. The rows are loaded through a single row-write port and may be rewritten at any time while the block keeps evaluating.

Each plane can be set to AND, NAND, OR or NOR, so the array can be built as AND-then-OR, NAND-then-NAND or the dual forms. Two row encodings are supported, and one input selects which of them applies to both planes. In the literal-column form, each input owns a true column and a complement column. In the coded form, each input owns a two-bit code that can exclude it, select its true or complement value, or block the row. A mode input chooses whether the output follows the inputs combinationally or is held in a register that is loaded on each rising clock edge.

Top module: `sop_logic_array`

## Requirements
- R1: The function codes are the same for both planes: 00 gives AND, 01 gives NAND, 10 gives OR and 11 gives NOR. For input i, bit 2i+1 of a row belongs to the true value of the input and bit 2i belongs to its complement. With literal-column encoding (`plane_fmt`=0), a set bit adds that literal to the row's gate.
- R2: With coded encoding (`plane_fmt`=1), the two bits for input i are read as one code. Code 00 excludes the input, 10 takes its true value and 01 takes its complement. Code 11 forces the row's gate result to 0 before any inversion, so a NAND or NOR row then gives 1.
- R3: With literal-column encoding, a row that has both columns of one input set receives both literals. That row's AND therefore gives 0 and its OR gives 1.
- R4: The terms of the first plane are its rows, with row k giving term k. Output bit j is row j of the second plane, evaluated over those terms. As an example, take product rows xy', xz, y'z and x'yz'. Let f1 be the OR of terms {0,1,3} and f2 the OR of terms {1,2}. Then xyz=101 gives f1=f2=1, and xyz=110 gives 0 on both.
- R5: A row with no literal selected gives 1 under AND, 0 under NAND, 0 under OR and 1 under NOR.
- R6: When `sync_mode`=0, `dout` follows changes of `din`, of the function codes and of the row contents with no clock edge in between.
- R7: When `sync_mode`=1, `dout` changes only at a rising clock edge. After the edge it shows the result computed from `din` and the rows as they were just before that edge.
- R8: A row write is taken at the rising edge when `wr_en` is high. `wr_plane`=0 targets first-plane row `wr_row` and uses the low 2·N_IN bits of `wr_data`. `wr_plane`=1 targets second-plane row `wr_row` and uses the low 2·N_TERM bits. Combinational evaluation uses the new row as soon as that edge has passed.
- R9: A write whose `wr_row` is not below the row count of the selected plane changes no row.
- R10: While `rst_n` is low, every row of both planes is cleared and the output register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for row writes and the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_mode | input | 1 | 1 selects the registered output, 0 selects the combinational output |
| plane_fmt | input | 1 | Row encoding: 0 for literal columns, 1 for two-bit codes |
| and_fn | input | 2 | Gate function of the first plane |
| or_fn | input | 2 | Gate function of the second plane |
| wr_en | input | 1 | Row write strobe |
| wr_plane | input | 1 | Plane that is written: 0 for the first, 1 for the second |
| wr_row | input | IDX_W | Index of the row that is written |
| wr_data | input | 2·max(N_IN,N_TERM) | Contents of the new row |
| din | input | N_IN | Primary inputs |
| dout | output | N_OUT | Array outputs |

## Verification
The hardest case to set up is a row write that lands on the same edge as the output register update in registered mode. The register must capture the old contents at that edge and show the new contents one edge later. The bench holds `din` fixed, raises the write strobe for exactly one edge and samples the output after each of the two edges. The blocking code 11 and the doubled literal columns look the same in a first-plane AND row but differ in a second-plane OR row. For that reason, the full sweeps over every input value cover all sixteen function pairings under both encodings, using rows that contain those codes in both planes.

// File: rtl/pla_pkg.sv
package pla_pkg;

    typedef enum logic [1:0] {
        GATE_AND  = 2'b00,
        GATE_NAND = 2'b01,
        GATE_OR   = 2'b10,
        GATE_NOR  = 2'b11
    } gate_fn_e;

    typedef enum logic [1:0] {
        CODE_SKIP = 2'b00,
        CODE_INV  = 2'b01,
        CODE_TRUE = 2'b10,
        CODE_KILL = 2'b11
    } cell_code_e;

    function automatic logic fn_is_sum(input gate_fn_e f);
        return (f == GATE_OR) || (f == GATE_NOR);
    endfunction

    function automatic logic fn_inverts(input gate_fn_e f);
        return (f == GATE_NAND) || (f == GATE_NOR);
    endfunction

endpackage

// File: rtl/pla_row_gate.sv
module pla_row_gate
    import pla_pkg::*;
#(
    parameter int N_LIT = 8
) (
    input  logic [N_LIT-1:0]   lit,
    input  logic [2*N_LIT-1:0] sel,
    input  logic               plane_fmt,
    input  gate_fn_e           fn,
    output logic               y
);

    logic prod_acc;
    logic sum_acc;
    logic kill;
    logic core;

    always_comb begin
        prod_acc = 1'b1;
        sum_acc  = 1'b0;
        kill     = 1'b0;
        for (int i = 0; i < N_LIT; i++) begin
            if (plane_fmt && (sel[2*i +: 2] == CODE_KILL)) begin
                kill = 1'b1;
            end else begin
                if (sel[2*i+1]) begin
                    prod_acc = prod_acc & lit[i];
                    sum_acc  = sum_acc | lit[i];
                end
                if (sel[2*i]) begin
                    prod_acc = prod_acc & ~lit[i];
                    sum_acc  = sum_acc | ~lit[i];
                end
            end
        end
        core = fn_is_sum(fn) ? sum_acc : prod_acc;
        if (kill) begin
            core = 1'b0;
        end
        y = core ^ fn_inverts(fn);
    end

endmodule

// File: rtl/pla_plane.sv
module pla_plane
    import pla_pkg::*;
#(
    parameter int N_LIT  = 8,
    parameter int N_ROWS = 4,
    parameter int IDX_W  = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [IDX_W-1:0]                wr_row,
    input  logic [2*N_LIT-1:0]              wr_data,
    input  logic                            plane_fmt,
    input  gate_fn_e                        fn,
    input  logic [N_LIT-1:0]                lit,
    output logic [N_ROWS-1:0][2*N_LIT-1:0]  rows,
    output logic [N_ROWS-1:0]               terms
);

    localparam int ROW_W = 2 * N_LIT;

    typedef struct packed {
        logic [N_ROWS-1:0][ROW_W-1:0] row;
    } store_t;

    store_t store_d;
    store_t store_q;

    always_comb begin
        store_d = store_q;
        for (int r = 0; r < N_ROWS; r++) begin
            if (wr_en && (wr_row == IDX_W'(r))) begin
                store_d.row[r] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            store_q <= '0;
        end else begin
            store_q <= store_d;
        end
    end

    assign rows = store_q.row;

    for (genvar g = 0; g < N_ROWS; g++) begin : g_row
        pla_row_gate #(
            .N_LIT (N_LIT)
        ) u_row (
            .lit       (lit),
            .sel       (store_q.row[g]),
            .plane_fmt (plane_fmt),
            .fn        (fn),
            .y         (terms[g])
        );
    end

endmodule

// File: rtl/sop_logic_array.sv
module sop_logic_array
    import pla_pkg::*;
#(
    parameter  int N_IN    = 8,
    parameter  int N_TERM  = 4,
    parameter  int N_OUT   = 3,
    localparam int ROW_MAX = (N_TERM > N_OUT) ? N_TERM : N_OUT,
    localparam int IDX_W   = (ROW_MAX > 1) ? $clog2(ROW_MAX) : 1,
    localparam int LIT_MAX = (N_IN > N_TERM) ? N_IN : N_TERM
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sync_mode,
    input  logic                   plane_fmt,
    input  logic [1:0]             and_fn,
    input  logic [1:0]             or_fn,
    input  logic                   wr_en,
    input  logic                   wr_plane,
    input  logic [IDX_W-1:0]       wr_row,
    input  logic [2*LIT_MAX-1:0]   wr_data,
    input  logic [N_IN-1:0]        din,
    output logic [N_OUT-1:0]       dout
);

    typedef struct packed {
        logic [N_OUT-1:0] held;
    } out_t;

    gate_fn_e                          and_gate;
    gate_fn_e                          or_gate;
    logic [N_TERM-1:0]                 prod;
    logic [N_OUT-1:0]                  sop_out;
    logic [N_OUT-1:0]                  held_out;
    logic [N_TERM-1:0][2*N_IN-1:0]     and_rows;
    logic [N_OUT-1:0][2*N_TERM-1:0]    or_rows;
    out_t                              out_d;
    out_t                              out_q;

    assign and_gate = gate_fn_e'(and_fn);
    assign or_gate  = gate_fn_e'(or_fn);

    pla_plane #(
        .N_LIT  (N_IN),
        .N_ROWS (N_TERM),
        .IDX_W  (IDX_W)
    ) u_and_plane (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en & ~wr_plane),
        .wr_row    (wr_row),
        .wr_data   (wr_data[2*N_IN-1:0]),
        .plane_fmt (plane_fmt),
        .fn        (and_gate),
        .lit       (din),
        .rows      (and_rows),
        .terms     (prod)
    );

    pla_plane #(
        .N_LIT  (N_TERM),
        .N_ROWS (N_OUT),
        .IDX_W  (IDX_W)
    ) u_or_plane (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en & wr_plane),
        .wr_row    (wr_row),
        .wr_data   (wr_data[2*N_TERM-1:0]),
        .plane_fmt (plane_fmt),
        .fn        (or_gate),
        .lit       (prod),
        .rows      (or_rows),
        .terms     (sop_out)
    );

    always_comb begin
        out_d      = out_q;
        out_d.held = sop_out;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign held_out = out_q.held;
    assign dout     = sync_mode ? held_out : sop_out;

endmodule

// File: rtl/pla_checker.sv
module pla_checker #(
    parameter  int N_IN    = 8,
    parameter  int N_TERM  = 4,
    parameter  int N_OUT   = 3,
    parameter  int IDX_W   = 2,
    localparam int LIT_MAX = (N_IN > N_TERM) ? N_IN : N_TERM
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          sync_mode,
    input logic [1:0]                    and_fn,
    input logic                          wr_en,
    input logic                          wr_plane,
    input logic [IDX_W-1:0]              wr_row,
    input logic [2*LIT_MAX-1:0]          wr_data,
    input logic [N_OUT-1:0]              dout,
    input logic [N_OUT-1:0]              comb_out,
    input logic [N_OUT-1:0]              held_out,
    input logic [N_TERM-1:0][2*N_IN-1:0] and_rows,
    input logic [N_OUT-1:0][2*N_TERM-1:0] or_rows,
    input logic [N_TERM-1:0]             prod
);

    logic armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else begin
            armed_q <= 1'b1;
        end
    end

    assert_reset_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !armed_q |-> (held_out == '0) && (and_rows == '0) && (or_rows == '0));

    assert_sync_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && sync_mode) |-> (dout == $past(comb_out)));

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(and_rows) && $stable(or_rows));

    assert_bad_row_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_plane && (int'(wr_row) >= N_OUT)) |=> $stable(or_rows) && $stable(and_rows));

    assert_empty_row_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (and_rows[0] == '0) |-> (prod[0] == ((and_fn == 2'b00) || (and_fn == 2'b11))));

    for (genvar r = 0; r < N_TERM; r++) begin : g_and_chk
        assert_and_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !wr_plane && (wr_row == IDX_W'(r))) |=> (and_rows[r] == $past(wr_data[2*N_IN-1:0])));
    end

    for (genvar r = 0; r < N_OUT; r++) begin : g_or_chk
        assert_or_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_plane && (wr_row == IDX_W'(r))) |=> (or_rows[r] == $past(wr_data[2*N_TERM-1:0])));
    end

endmodule

bind sop_logic_array pla_checker #(
    .N_IN   (N_IN),
    .N_TERM (N_TERM),
    .N_OUT  (N_OUT),
    .IDX_W  (IDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_mode (sync_mode),
    .and_fn    (and_fn),
    .wr_en     (wr_en),
    .wr_plane  (wr_plane),
    .wr_row    (wr_row),
    .wr_data   (wr_data),
    .dout      (dout),
    .comb_out  (sop_out),
    .held_out  (held_out),
    .and_rows  (and_rows),
    .or_rows   (or_rows),
    .prod      (prod)
);

// File: tb/sop_logic_array_tb.sv
module sop_logic_array_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync_mode = 1'b0;
    logic        plane_fmt = 1'b0;
    logic [1:0]  and_fn = 2'b00;
    logic [1:0]  or_fn = 2'b10;
    logic        wr_en = 1'b0;
    logic        wr_plane = 1'b0;
    logic [1:0]  wr_row = 2'b00;
    logic [15:0] wr_data = '0;
    logic [7:0]  din = '0;
    logic [2:0]  dout;

    int n_tests = 0;
    int n_fail  = 0;

    logic [15:0] and_mem [4];
    logic [15:0] or_mem  [3];

    always #10 clk = ~clk;

    sop_logic_array u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_mode (sync_mode),
        .plane_fmt (plane_fmt),
        .and_fn    (and_fn),
        .or_fn     (or_fn),
        .wr_en     (wr_en),
        .wr_plane  (wr_plane),
        .wr_row    (wr_row),
        .wr_data   (wr_data),
        .din       (din),
        .dout      (dout)
    );

    // Reference row: collect literal values, then combine per function.
    function automatic logic mrow(input logic [15:0] sel, input logic [7:0] lit,
                                  input int n, input logic fmt, input logic [1:0] fn);
        int  ones  = 0;
        int  zeros = 0;
        bit  kill  = 0;
        logic core;
        for (int i = 0; i < n; i++) begin
            if (fmt && sel[2*i+1] && sel[2*i]) kill = 1;
            else begin
                if (sel[2*i+1]) begin if (lit[i]) ones++; else zeros++; end
                if (sel[2*i])   begin if (!lit[i]) ones++; else zeros++; end
            end
        end
        core = fn[1] ? (ones > 0) : (zeros == 0);
        if (kill) core = 1'b0;
        return core ^ fn[0];
    endfunction

    function automatic logic [2:0] mexp(input logic [7:0] v);
        logic [7:0] p = '0;
        logic [2:0] o;
        for (int k = 0; k < 4; k++) p[k] = mrow(and_mem[k], v, 8, plane_fmt, and_fn);
        for (int j = 0; j < 3; j++) o[j] = mrow(or_mem[j], p, 4, plane_fmt, or_fn);
        return o;
    endfunction

    function automatic logic [15:0] true_sel(input logic [7:0] m);
        logic [15:0] s = '0;
        for (int i = 0; i < 8; i++) s[2*i+1] = m[i];
        return s;
    endfunction

    task automatic chk(input string req, input logic [2:0] got, input logic [2:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    task automatic wr(input logic pl, input int row, input logic [15:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_plane = pl; wr_row = 2'(row); wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
        if (!pl) and_mem[row] = data;
        else if (row < 3) or_mem[row] = data;
    endtask

    task automatic cfg(input logic f, input logic [1:0] af, input logic [1:0] of);
        @(negedge clk);
        plane_fmt = f; and_fn = af; or_fn = of;
    endtask

    task automatic sweep(input string req);
        for (int v = 0; v < 256; v++) begin
            @(negedge clk);
            din = 8'(v);
            #2;
            chk(req, dout, mexp(8'(v)));
        end
    endtask

    task automatic load_ex1();
        wr(0, 0, true_sel(8'h33));
        wr(0, 1, true_sel(8'hCC));
        wr(0, 2, true_sel(8'hF0));
        wr(0, 3, 16'h0000);
        wr(1, 0, true_sel(8'h01));
        wr(1, 1, true_sel(8'h02));
        wr(1, 2, true_sel(8'h04));
    endtask

    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [2:0] prev;
        for (int k = 0; k < 4; k++) and_mem[k] = '0;
        for (int j = 0; j < 3; j++) or_mem[j] = '0;
        repeat (3) @(negedge clk);
        #2;
        chk("R10 reset comb", dout, 3'b000);
        sync_mode = 1'b1; #1;
        chk("R10 reset reg", dout, 3'b000);
        sync_mode = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        // R1 R4: eight-input AND plane example, pass-through OR rows
        load_ex1();
        @(negedge clk); din = 8'hFC; #2; chk("R1 example A", dout, 3'b110);
        @(negedge clk); din = 8'h55; #2; chk("R1 example B", dout, 3'b000);
        sweep("R1 R4 array AND/OR sweep");

        // R6: change mid-cycle, no edge in between
        @(posedge clk); #5; din = 8'hF3; #1; chk("R6 async follow", dout, mexp(8'hF3));

        // R8: rewrite during operation, async sees it right after the edge
        @(negedge clk); din = 8'hFC;
        wr(0, 0, true_sel(8'h0C)); #2; chk("R8 async rewrite", dout, 3'b111);
        wr(0, 0, true_sel(8'h33)); #2; chk("R8 async restore", dout, 3'b110);

        // R5: empty AND row 0 under each first-plane function
        wr(0, 0, 16'h0000);
        for (int af = 0; af < 4; af++) begin
            cfg(1'b0, 2'(af), 2'b10);
            din = 8'h5A; #2;
            chk("R5 empty product row", {2'b00, dout[0]}, {2'b00, (af == 0 || af == 3)});
        end
        wr(1, 1, 16'h0000);
        for (int of = 0; of < 4; of++) begin
            cfg(1'b0, 2'b00, 2'(of));
            din = 8'hA5; #2;
            chk("R5 empty sum row", {2'b00, dout[1]}, {2'b00, (of == 0 || of == 3)});
        end

        // R2 R4: coded two-plane example, x=din[0], y=din[1], z=din[2]
        wr(0, 0, 16'h0006);
        wr(0, 1, 16'h0022);
        wr(0, 2, 16'h0024);
        wr(0, 3, 16'h0019);
        wr(1, 0, 16'h008A);
        wr(1, 1, 16'h0028);
        wr(1, 2, 16'h0000);
        cfg(1'b1, 2'b00, 2'b10);
        din = 8'h05; #2; chk("R4 xyz=101", dout, 3'b011);
        @(negedge clk); din = 8'h03; #2; chk("R4 xyz=110", dout, 3'b000);
        cfg(1'b1, 2'b01, 2'b01);
        din = 8'h05; #2; chk("R4 NAND-NAND xyz=101", dout, 3'b011);

        // R2 vs R3: both bits set on one literal
        wr(0, 3, 16'h0C19);
        wr(1, 2, 16'h0023);
        cfg(1'b1, 2'b00, 2'b10);
        din = 8'h05; #2; chk("R2 blocking code in sum row", dout, 3'b011);
        cfg(1'b0, 2'b00, 2'b10);
        din = 8'h05; #2; chk("R3 doubled literal in sum row", dout, 3'b111);

        for (int f = 0; f < 2; f++)
            for (int af = 0; af < 4; af++)
                for (int of = 0; of < 4; of++) begin
                    cfg(1'(f), 2'(af), 2'(of));
                    sweep(f ? "R1 R2 R4 coded sweep" : "R1 R3 R4 array sweep");
                end

        // R9: out-of-range second-plane row
        cfg(1'b1, 2'b00, 2'b10);
        wr(1, 3, 16'hFFFF);
        sweep("R9 ignored row write");

        // R7: registered mode
        load_ex1();
        cfg(1'b0, 2'b00, 2'b10);
        sync_mode = 1'b1; din = 8'h00;
        @(posedge clk); prev = mexp(8'h00);
        for (int v = 0; v < 256; v++) begin
            @(negedge clk); din = 8'(v); #2;
            chk("R7 hold between edges", dout, prev);
            @(posedge clk); #2;
            chk("R7 update at edge", dout, mexp(8'(v)));
            prev = mexp(8'(v));
        end
        @(negedge clk); din = 8'hFC;
        @(posedge clk); #2; chk("R7 settle", dout, 3'b110);
        @(negedge clk);
        wr_en = 1'b1; wr_plane = 1'b0; wr_row = 2'd0; wr_data = true_sel(8'h0C);
        @(posedge clk); #2; chk("R7 write edge keeps old rows", dout, 3'b110);
        @(negedge clk); wr_en = 1'b0; and_mem[0] = true_sel(8'h0C);
        @(posedge clk); #2; chk("R8 next edge uses new row", dout, 3'b111);

        // R10: reset in operation
        @(negedge clk); rst_n = 1'b0; #2;
        chk("R10 reset reg mid-run", dout, 3'b000);
        sync_mode = 1'b0; #1;
        chk("R10 reset comb mid-run", dout, 3'b000);
        @(negedge clk); rst_n = 1'b1;
        for (int k = 0; k < 4; k++) and_mem[k] = '0;
        for (int j = 0; j < 3; j++) or_mem[j] = '0;
        cfg(1'b1, 2'b01, 2'b01);
        sweep("R10 rows cleared");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule